// File: doc/BRIEF.md
# Flash Sector Write-Protection Guard

This block keeps the status register of a serial NOR flash and uses its block-protect field to decide which program and erase requests may proceed. A four-bit protect code selects a power-of-two number of sectors. A separate direction bit places that range against the highest sector or against sector 0. A write-enable latch gates every change to the status register and every accepted program or erase. The latch drops again after each such operation.

Commands arrive one per cycle as a valid strobe, an operation code, a byte address and a data byte. Every result is registered. In the cycle after a command, the status output shows the new register contents, and exactly one of two pulses may be raised: a grant for accepted work, or a protection error for a refused program or erase. Reads are always granted. Command decoding from the serial bus and the array storage are handled outside this block.

Top module: `flash_bp_guard`

## Requirements
- R1: After reset the status output is 8'h00, and both req_ok and prot_err are low.
- R2: Operation codes are 1 = set write-enable, 2 = clear write-enable, 3 = status write, 4 = program, 5 = sector erase, 6 = read; any other code has no effect. Status bit 1 shows the write-enable latch, and code 1 sets it while code 2 clears it.
- R3: A status write made while the latch is set loads status bits 7..2 from data bits 7..2 and clears the latch. Status bit 0 always reads 0. The layout is bit 2 = P0, bit 3 = P1, bit 4 = P2, bit 5 = direction, bit 6 = P3, bit 7 = status-lock flag.
- R4: A status write made while the latch is clear leaves the status register unchanged.
- R5: A protect code {P3,P2,P1,P0} of zero protects no sector, whatever the direction bit holds.
- R6: A nonzero code n with the direction bit clear protects the top 2^(n-1) sectors. The sector index is address bits [26:16] (2048 sectors of 64 KiB).
- R7: A nonzero code n with the direction bit set protects sectors 0 to 2^(n-1)-1.
- R8: When 2^(n-1) reaches or exceeds the sector count, the whole array is protected in either direction.
- R9: A program or erase aimed at a protected sector raises prot_err for one cycle, raises no req_ok, and leaves the latch clear.
- R10: A program or erase aimed at an unprotected sector while the latch is set raises req_ok for one cycle and clears the latch.
- R11: A program or erase aimed at an unprotected sector while the latch is clear raises neither pulse.
- R12: A read raises req_ok whether or not its sector is protected, and it leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_addr | input | 27 | Byte address of program, erase or read |
| cmd_wdata | input | 8 | New status value for a status write |
| status_out | output | 8 | Status register with the latch in bit 1 |
| req_ok | output | 1 | One-cycle grant pulse |
| prot_err | output | 1 | One-cycle protection-refusal pulse |

## Verification
The protection decision and the latch update can fall in the same cycle: a refused erase must raise its error and clear the latch in the same registered update, and a read to a protected sector must be granted while the latch stays set. The bench provokes both by setting the latch and then aiming an erase, and separately a read, at a sector inside the current range. It then judges the pulse and status bit 1 together in the following cycle. A table of protect codes, each probed just inside and just outside its range edge, checks the range arithmetic in both directions.

// File: rtl/flash_bp_pkg.sv
package flash_bp_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WREN  = 3'd1,
        OP_WRDI  = 3'd2,
        OP_WRSR  = 3'd3,
        OP_PROG  = 3'd4,
        OP_ERASE = 3'd5,
        OP_READ  = 3'd6
    } flash_op_e;

    // Stored status bits 7..2; index k of this field is status bit k+2.
    typedef struct packed {
        logic       lock;   // status bit 7
        logic       p3;     // status bit 6
        logic       dir;    // status bit 5
        logic [2:0] p_lo;   // status bits 4..2
    } sr_field_t;

    typedef struct packed {
        sr_field_t sr;
        logic      wel;
        logic      ok;
        logic      err;
    } guard_state_t;

endpackage

// File: rtl/bp_range_decode.sv
module bp_range_decode #(
    parameter int NSECT  = 2048,
    parameter int SECT_W = $clog2(NSECT)
) (
    input  logic [3:0]        code,
    input  logic              from_bottom,
    output logic              range_en,
    output logic [SECT_W-1:0] range_lo,
    output logic [SECT_W-1:0] range_hi
);
    localparam int LEN_W = SECT_W + 1;

    logic [LEN_W-1:0] len_tbl [16];
    logic [LEN_W-1:0] len_sel;
    logic [LEN_W-1:0] top_lo;
    logic [LEN_W-1:0] bot_hi;

    // One length per code, clamped to the array size.
    assign len_tbl[0] = '0;
    for (genvar g = 1; g < 16; g++) begin : g_len
        localparam int SH = g - 1;
        localparam longint LEN = (SH >= SECT_W) ? longint'(NSECT) : (longint'(1) << SH);
        assign len_tbl[g] = LEN_W'(LEN);
    end

    always_comb begin
        len_sel  = len_tbl[code];
        top_lo   = LEN_W'(NSECT) - len_sel;
        bot_hi   = len_sel - LEN_W'(1);
        range_en = (code != 4'd0);
        if (from_bottom) begin
            range_lo = '0;
            range_hi = bot_hi[SECT_W-1:0];
        end else begin
            range_lo = top_lo[SECT_W-1:0];
            range_hi = SECT_W'(NSECT - 1);
        end
    end

endmodule

// File: rtl/bp_sector_match.sv
module bp_sector_match #(
    parameter int SECT_W = 11
) (
    input  logic              range_en,
    input  logic [SECT_W-1:0] range_lo,
    input  logic [SECT_W-1:0] range_hi,
    input  logic [SECT_W-1:0] sector,
    output logic              hit
);
    always_comb begin
        hit = range_en && (sector >= range_lo) && (sector <= range_hi);
    end
endmodule

// File: rtl/flash_bp_guard.sv
module flash_bp_guard
    import flash_bp_pkg::*;
#(
    parameter int NSECT      = 2048,
    parameter int SECT_BYTES = 65536,
    parameter int ADDR_W     = $clog2(NSECT) + $clog2(SECT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic [7:0]        status_out,
    output logic              req_ok,
    output logic              prot_err
);
    localparam int SECT_W = $clog2(NSECT);
    localparam int OFF_W  = ADDR_W - SECT_W;

    guard_state_t st_q, st_d;

    logic [SECT_W-1:0] sector;
    logic [3:0]        code;
    logic              range_en;
    logic [SECT_W-1:0] range_lo;
    logic [SECT_W-1:0] range_hi;
    logic              hit;
    logic              offset_unused;
    logic              wdata_unused;

    assign sector        = cmd_addr[ADDR_W-1 -: SECT_W];
    assign offset_unused = ^cmd_addr[OFF_W-1:0];
    assign wdata_unused  = ^cmd_wdata[1:0];
    assign code          = {st_q.sr.p3, st_q.sr.p_lo};

    bp_range_decode #(.NSECT(NSECT), .SECT_W(SECT_W)) u_decode (
        .code        (code),
        .from_bottom (st_q.sr.dir),
        .range_en    (range_en),
        .range_lo    (range_lo),
        .range_hi    (range_hi)
    );

    bp_sector_match #(.SECT_W(SECT_W)) u_match (
        .range_en (range_en),
        .range_lo (range_lo),
        .range_hi (range_hi),
        .sector   (sector),
        .hit      (hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ok  = 1'b0;
        st_d.err = 1'b0;
        if (cmd_valid) begin
            case (flash_op_e'(cmd_op))
                OP_WREN: st_d.wel = 1'b1;
                OP_WRDI: st_d.wel = 1'b0;
                OP_WRSR: begin
                    if (st_q.wel) begin
                        st_d.sr  = sr_field_t'(cmd_wdata[7:2]);
                        st_d.wel = 1'b0;
                    end
                end
                OP_PROG, OP_ERASE: begin
                    if (hit) begin
                        st_d.err = 1'b1;
                        st_d.wel = 1'b0;
                    end else if (st_q.wel) begin
                        st_d.ok  = 1'b1;
                        st_d.wel = 1'b0;
                    end
                end
                OP_READ: st_d.ok = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_out = {st_q.sr, st_q.wel, 1'b0};
    assign req_ok     = st_q.ok;
    assign prot_err   = st_q.err;

endmodule

// File: rtl/flash_bp_guard_chk.sv
module flash_bp_guard_chk
    import flash_bp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic [7:0] status_out,
    input logic       req_ok,
    input logic       prot_err
);
    a_r9_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ok, prot_err}));

    a_r9_err_drops_latch: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> !status_out[1]);

    a_r12_read_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ) |=> req_ok);

    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WREN) |=> status_out[1]);

    a_r4_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRSR && !status_out[1]) |=> $stable(status_out[7:2]));

    a_r5_code_zero_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_PROG || cmd_op == OP_ERASE)
         && status_out[6] == 1'b0 && status_out[4:2] == 3'b000) |=> !prot_err);

    a_r3_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !status_out[0]);
endmodule

bind flash_bp_guard flash_bp_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .status_out (status_out),
    .req_ok     (req_ok),
    .prot_err   (prot_err)
);

// File: tb/flash_bp_guard_test.sv
`timescale 1ns/1ps
module flash_bp_guard_test;
    import flash_bp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [26:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic [7:0]  status_out;
    logic        req_ok;
    logic        prot_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_bp_guard uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .status_out(status_out), .req_ok(req_ok), .prot_err(prot_err)
    );

    // {status value, sector, expected refusal}
    localparam int NV = 22;
    localparam logic [19:0] VEC [NV] = '{
        {8'h04, 11'd2047, 1'b1}, {8'h04, 11'd2046, 1'b0},
        {8'h08, 11'd2046, 1'b1}, {8'h08, 11'd2045, 1'b0},
        {8'h10, 11'd2040, 1'b1}, {8'h10, 11'd2039, 1'b0},
        {8'h40, 11'd1920, 1'b1}, {8'h40, 11'd1919, 1'b0},
        {8'h4C, 11'd1024, 1'b1}, {8'h4C, 11'd1023, 1'b0},
        {8'h6C, 11'd1023, 1'b1}, {8'h6C, 11'd1024, 1'b0},
        {8'h24, 11'd0,    1'b1}, {8'h24, 11'd1,    1'b0},
        {8'h34, 11'd15,   1'b1}, {8'h34, 11'd16,   1'b0},
        {8'h20, 11'd0,    1'b0}, {8'h00, 11'd2047, 1'b0},
        {8'h50, 11'd0,    1'b1}, {8'h7C, 11'd2047, 1'b1},
        {8'h5C, 11'd0,    1'b1}, {8'h80, 11'd2047, 1'b0}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one command across a rising edge; results are visible on return.
    task automatic issue(flash_op_e op, logic [26:0] addr, logic [7:0] data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        cmd_wdata = data;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        cmd_op    = OP_NONE;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 status", status_out, 8'h00);
        check("R1 pulses", {6'd0, req_ok, prot_err}, 8'h00);
        rst_n = 1'b1;
        idle();

        // Table walk: R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  sr_v;
            logic [10:0] sec_v;
            logic        bad_v;
            {sr_v, sec_v, bad_v} = VEC[i];
            issue(OP_WREN, '0, 8'h00);
            issue(OP_WRSR, '0, sr_v);
            check("R3 table status", status_out, sr_v);
            issue(OP_WREN, '0, 8'h00);
            issue((i % 2 == 0) ? OP_ERASE : OP_PROG,
                  {sec_v, (i % 2 == 0) ? 16'h0000 : 16'hFFFF}, 8'h00);
            check(bad_v ? "R6/R7/R8 R9 refuse" : "R5/R6/R7 R10 grant",
                  {6'd0, req_ok, prot_err}, bad_v ? 8'h01 : 8'h02);
            check("R9 R10 latch cleared", {7'd0, status_out[1]}, 8'h00);
        end

        // R2 latch set and clear, unused op code
        issue(OP_WREN, '0, 8'h00);
        check("R2 set latch", {7'd0, status_out[1]}, 8'h01);
        issue(flash_op_e'(3'd7), '0, 8'hFF);
        check("R2 unused op", status_out, 8'h82);
        issue(OP_WRDI, '0, 8'h00);
        check("R2 clear latch", {7'd0, status_out[1]}, 8'h00);

        // R3 low data bits ignored
        issue(OP_WREN, '0, 8'h00);
        issue(OP_WRSR, '0, 8'hFF);
        check("R3 low bits", status_out, 8'hFC);

        // R4 write without latch
        issue(OP_WRSR, '0, 8'h00);
        check("R4 locked write", status_out, 8'hFC);

        // Set code 1, top: only sector 2047 protected
        issue(OP_WREN, '0, 8'h00);
        issue(OP_WRSR, '0, 8'h04);
        check("R3 reload", status_out, 8'h04);

        // R12 read on protected sector with latch set, latch stays
        issue(OP_WREN, '0, 8'h00);
        issue(OP_READ, {11'd2047, 16'h1234}, 8'h00);
        check("R12 read grant", {6'd0, req_ok, prot_err}, 8'h02);
        check("R12 latch kept", {7'd0, status_out[1]}, 8'h01);

        // R9 refused erase clears latch in the same update, single pulse
        issue(OP_ERASE, {11'd2047, 16'h0000}, 8'h00);
        check("R9 refuse", {6'd0, req_ok, prot_err}, 8'h01);
        check("R9 latch", {7'd0, status_out[1]}, 8'h00);
        idle();
        check("R9 one cycle", {6'd0, req_ok, prot_err}, 8'h00);

        // R11 program without latch on open sector
        issue(OP_PROG, {11'd5, 16'h0010}, 8'h00);
        check("R11 no pulse", {6'd0, req_ok, prot_err}, 8'h00);
        check("R11 status", status_out, 8'h04);

        // R10 grant pulse is single cycle
        issue(OP_WREN, '0, 8'h00);
        issue(OP_PROG, {11'd5, 16'h0010}, 8'h00);
        check("R10 grant", {6'd0, req_ok, prot_err}, 8'h02);
        idle();
        check("R10 one cycle", {6'd0, req_ok, prot_err}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule